// File: doc/BRIEF.md
# Indexed Colour Palette Lookup

This block turns a stream of 8-bit pixel indices into 24-bit display colours. Each index selects one of 256 palette entries. An entry is 16 bits wide and packs red, green and blue at 5, 6 and 5 bits. The chosen entry is widened to 8 bits per component and registered onto the colour bus, one cycle after the index arrives. A data-enable signal travels alongside the index and comes out delayed by the same cycle.

A host write port loads the palette. A video-status input tells the block when the display is scanning its active region. During that time the palette must not change, so a write that arrives then is parked in a one-entry holding register. It lands in the palette on the next blanking cycle, and a busy flag is raised until it does. A separate override register can force every displayed pixel to a single 24-bit colour. While the override is on, the palette is bypassed but can still be written.

Top module: `idx_palette_map`

## Requirements
- R1: After reset, `rgb_o` is 0, `de_o` is 0, `wr_busy_o` is 0, the override is off and every palette entry is 0.
- R2: `de_o` equals `pix_valid_i` of the previous cycle. With the override off, a valid index produces the colour of its entry on `rgb_o` in the next cycle.
- R3: An entry holds red in bits 15:11, green in bits 10:5 and blue in bits 4:0. Each component is widened by appending its top bits below it: red 8 = {r5, r5[4:2]}, green 8 = {g6, g6[5:4]}, blue 8 = {b5, b5[4:2]}. The result is packed as `rgb_o` = {red, green, blue}.
- R4: When `pix_valid_i` is low, `rgb_o` is 0 in the next cycle.
- R5: A write with `active_i` low is stored at that clock edge. A lookup of the same entry in that same cycle returns the old value, and a lookup in the following cycle returns the new one.
- R6: A write with `active_i` high does not touch the palette while `active_i` stays high. `wr_busy_o` is high from the next cycle.
- R7: A held write is stored on the first cycle in which `active_i` is low, and `wr_busy_o` drops after that edge. Lookups from the next cycle return the new value.
- R8: A second write during active video, while one is already held, replaces the held write, so the last write wins.
- R9: A write arriving in a blanking cycle while another is held becomes the new held write. The old held write is stored in that cycle, `wr_busy_o` stays high, and the new write is stored on the next blanking cycle.
- R10: An override write with bit 24 set stores bits 23:0 (0xRRGGBB). Valid pixels presented from the next cycle on show that colour, whatever the palette holds.
- R11: An override write with bit 24 clear turns the override off. A pixel presented in the same cycle as that write still shows the override colour. Pixels presented afterwards use the palette.
- R12: Palette writes made while the override is on are stored, and they show once the override is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| active_i | input | 1 | High while the display scans its active region |
| pix_valid_i | input | 1 | Pixel data enable for the index |
| pix_idx_i | input | 8 | Pixel palette index |
| wr_en_i | input | 1 | Palette write strobe |
| wr_addr_i | input | 8 | Palette entry to write |
| wr_data_i | input | 16 | Entry value, 5:6:5 |
| ovr_wr_i | input | 1 | Override register write strobe |
| ovr_data_i | input | 25 | Bit 24 enable, bits 23:0 colour |
| rgb_o | output | 24 | Registered output colour {R,G,B} |
| de_o | output | 1 | Delayed data enable |
| wr_busy_o | output | 1 | A palette write is held pending |

## Verification
The functions that can fall in the same cycle are a palette store and a pixel lookup of the same entry. A store can come from a direct blanking write or from a held write that commits as active video ends. The bench presents both in one cycle and checks that the output shows the old colour, then the new colour one cycle later. It also makes an override clear coincide with a pixel and checks that this pixel keeps the override colour while the next pixel uses the palette.

// File: rtl/pal_pkg.sv
package pal_pkg;
    localparam int ENT_W  = 16;
    localparam int RGB_W  = 24;
    localparam int OVR_W  = RGB_W + 1;
    localparam int OVR_EN = RGB_W;

    typedef logic [ENT_W-1:0] entry_t;
    typedef logic [RGB_W-1:0] rgb_t;

    function automatic rgb_t widen_565(input entry_t e);
        logic [4:0] r5;
        logic [5:0] g6;
        logic [4:0] b5;
        r5 = e[15:11];
        g6 = e[10:5];
        b5 = e[4:0];
        return {r5, r5[4:2], g6, g6[5:4], b5, b5[4:2]};
    endfunction
endpackage

// File: rtl/pal_store.sv
module pal_store #(
    parameter int IDX_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 we_i,
    input  logic [IDX_W-1:0]     waddr_i,
    input  pal_pkg::entry_t      wdata_i,
    input  logic [IDX_W-1:0]     raddr_i,
    output pal_pkg::entry_t      rdata_o
);
    localparam int DEPTH = 1 << IDX_W;

    pal_pkg::entry_t mem_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else if (we_i) begin
            mem_q[waddr_i] <= wdata_i;
        end
    end

    assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/pal_wr_gate.sv
module pal_wr_gate #(
    parameter int IDX_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 active_i,
    input  logic                 wr_en_i,
    input  logic [IDX_W-1:0]     wr_addr_i,
    input  pal_pkg::entry_t      wr_data_i,
    output logic                 cm_we_o,
    output logic [IDX_W-1:0]     cm_addr_o,
    output pal_pkg::entry_t      cm_data_o,
    output logic                 busy_o
);
    typedef struct packed {
        logic                vld;
        logic [IDX_W-1:0]    addr;
        pal_pkg::entry_t     data;
    } hold_t;

    hold_t hold_d, hold_q;

    always_comb begin
        hold_d    = hold_q;
        cm_we_o   = 1'b0;
        cm_addr_o = wr_addr_i;
        cm_data_o = wr_data_i;
        if (!active_i) begin
            if (hold_q.vld) begin
                cm_we_o   = 1'b1;
                cm_addr_o = hold_q.addr;
                cm_data_o = hold_q.data;
                if (wr_en_i) hold_d = '{vld: 1'b1, addr: wr_addr_i, data: wr_data_i};
                else         hold_d.vld = 1'b0;
            end else if (wr_en_i) begin
                cm_we_o = 1'b1;
            end
        end else if (wr_en_i) begin
            hold_d = '{vld: 1'b1, addr: wr_addr_i, data: wr_data_i};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hold_q <= '0;
        else        hold_q <= hold_d;
    end

    assign busy_o = hold_q.vld;
endmodule

// File: rtl/pal_out_stage.sv
module pal_out_stage (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         pix_valid_i,
    input  pal_pkg::entry_t              entry_i,
    input  logic                         ovr_wr_i,
    input  logic [pal_pkg::OVR_W-1:0]    ovr_data_i,
    output pal_pkg::rgb_t                rgb_o,
    output logic                         de_o
);
    typedef struct packed {
        pal_pkg::rgb_t  rgb;
        logic           de;
        logic           ovr_en;
        pal_pkg::rgb_t  ovr_rgb;
    } out_t;

    out_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.de = pix_valid_i;
        if (!pix_valid_i)    st_d.rgb = '0;
        else if (st_q.ovr_en) st_d.rgb = st_q.ovr_rgb;
        else                 st_d.rgb = pal_pkg::widen_565(entry_i);
        if (ovr_wr_i) begin
            st_d.ovr_en  = ovr_data_i[pal_pkg::OVR_EN];
            st_d.ovr_rgb = ovr_data_i[pal_pkg::RGB_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rgb_o = st_q.rgb;
    assign de_o  = st_q.de;
endmodule

// File: rtl/idx_palette_map.sv
module idx_palette_map #(
    parameter int IDX_W = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         active_i,
    input  logic                         pix_valid_i,
    input  logic [IDX_W-1:0]             pix_idx_i,
    input  logic                         wr_en_i,
    input  logic [IDX_W-1:0]             wr_addr_i,
    input  logic [pal_pkg::ENT_W-1:0]    wr_data_i,
    input  logic                         ovr_wr_i,
    input  logic [pal_pkg::OVR_W-1:0]    ovr_data_i,
    output logic [pal_pkg::RGB_W-1:0]    rgb_o,
    output logic                         de_o,
    output logic                         wr_busy_o
);
    logic              cm_we;
    logic [IDX_W-1:0]  cm_addr;
    pal_pkg::entry_t   cm_data;
    pal_pkg::entry_t   rd_entry;

    pal_wr_gate #(.IDX_W(IDX_W)) u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .active_i  (active_i),
        .wr_en_i   (wr_en_i),
        .wr_addr_i (wr_addr_i),
        .wr_data_i (wr_data_i),
        .cm_we_o   (cm_we),
        .cm_addr_o (cm_addr),
        .cm_data_o (cm_data),
        .busy_o    (wr_busy_o)
    );

    pal_store #(.IDX_W(IDX_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (cm_we),
        .waddr_i (cm_addr),
        .wdata_i (cm_data),
        .raddr_i (pix_idx_i),
        .rdata_o (rd_entry)
    );

    pal_out_stage u_out (
        .clk         (clk),
        .rst_n       (rst_n),
        .pix_valid_i (pix_valid_i),
        .entry_i     (rd_entry),
        .ovr_wr_i    (ovr_wr_i),
        .ovr_data_i  (ovr_data_i),
        .rgb_o       (rgb_o),
        .de_o        (de_o)
    );
endmodule

// File: rtl/pal_checker.sv
module pal_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        active_i,
    input logic        pix_valid_i,
    input logic        wr_en_i,
    input logic        ovr_wr_i,
    input logic [24:0] ovr_data_i,
    input logic [23:0] rgb_o,
    input logic        de_o,
    input logic        wr_busy_o,
    input logic        cm_we
);
    AST_NO_COMMIT_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n) cm_we |-> !active_i); // R6
    AST_HOLD_RAISES_BUSY: assert property (@(posedge clk) disable iff (!rst_n) (wr_en_i && active_i) |=> wr_busy_o); // R6
    AST_HELD_COMMITS: assert property (@(posedge clk) disable iff (!rst_n) (wr_busy_o && !active_i) |-> cm_we); // R7
    AST_BUSY_DROPS: assert property (@(posedge clk) disable iff (!rst_n) (wr_busy_o && !active_i && !wr_en_i) |=> !wr_busy_o); // R7
    AST_BUSY_STAYS: assert property (@(posedge clk) disable iff (!rst_n) (wr_busy_o && !active_i && wr_en_i) |=> wr_busy_o); // R9
    AST_DE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n) pix_valid_i |=> de_o); // R2
    AST_BLANK_BLACK: assert property (@(posedge clk) disable iff (!rst_n) !pix_valid_i |=> (!de_o && rgb_o == '0)); // R4
    AST_OVR_FORCES: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_wr_i && ovr_data_i[24]) ##1 (pix_valid_i && !ovr_wr_i) |=> rgb_o == $past(ovr_data_i[23:0], 2)); // R10
endmodule

bind idx_palette_map pal_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .active_i    (active_i),
    .pix_valid_i (pix_valid_i),
    .wr_en_i     (wr_en_i),
    .ovr_wr_i    (ovr_wr_i),
    .ovr_data_i  (ovr_data_i),
    .rgb_o       (rgb_o),
    .de_o        (de_o),
    .wr_busy_o   (wr_busy_o),
    .cm_we       (cm_we)
);

// File: tb/idx_palette_map_tb.sv
`timescale 1ns/1ps
module idx_palette_map_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        active_i = 1'b0;
    logic        pix_valid_i = 1'b0;
    logic [7:0]  pix_idx_i = '0;
    logic        wr_en_i = 1'b0;
    logic [7:0]  wr_addr_i = '0;
    logic [15:0] wr_data_i = '0;
    logic        ovr_wr_i = 1'b0;
    logic [24:0] ovr_data_i = '0;
    logic [23:0] rgb_o;
    logic        de_o;
    logic        wr_busy_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    idx_palette_map u_dut (
        .clk(clk), .rst_n(rst_n), .active_i(active_i), .pix_valid_i(pix_valid_i),
        .pix_idx_i(pix_idx_i), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
        .wr_data_i(wr_data_i), .ovr_wr_i(ovr_wr_i), .ovr_data_i(ovr_data_i),
        .rgb_o(rgb_o), .de_o(de_o), .wr_busy_o(wr_busy_o)
    );

    typedef struct packed {
        logic [7:0]  idx;
        logic [15:0] ent;
        logic [23:0] rgb;
    } vec_t;

    // R3 widening vectors: index, entry, expected colour
    localparam vec_t VECS [7] = '{
        '{8'd1,   16'hFFFF, 24'hFFFFFF},
        '{8'd2,   16'h0000, 24'h000000},
        '{8'd3,   16'hF800, 24'hFF0000},
        '{8'd77,  16'h07E0, 24'h00FF00},
        '{8'd128, 16'h001F, 24'h0000FF},
        '{8'd254, 16'h8410, 24'h848284},
        '{8'd255, 16'h0841, 24'h080808}
    };

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    initial begin
        #50000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        step(); step(); step();
        chk("R1 rgb", rgb_o, 0);
        chk("R1 de", de_o, 0);
        chk("R1 busy", wr_busy_o, 0);
        rst_n = 1'b1;
        step();
        pix_valid_i = 1; pix_idx_i = 200;
        step();
        chk("R1 entry zero", rgb_o, 0);
        chk("R2 de", de_o, 1);

        for (int i = 0; i < 7; i++) begin
            pix_valid_i = 0; wr_en_i = 1; wr_addr_i = VECS[i].idx; wr_data_i = VECS[i].ent;
            step();
            wr_en_i = 0; pix_valid_i = 1; pix_idx_i = VECS[i].idx;
            step();
            chk("R3 widen", rgb_o, VECS[i].rgb);
            chk("R2 de", de_o, 1);
        end

        pix_valid_i = 0;
        step();
        chk("R4 rgb", rgb_o, 0);
        chk("R4 de", de_o, 0);

        // R5: write and lookup of the same entry in one blanking cycle
        wr_en_i = 1; wr_addr_i = 10; wr_data_i = 16'hF800; pix_valid_i = 1; pix_idx_i = 10;
        step();
        chk("R5 old", rgb_o, 0);
        wr_en_i = 0;
        step();
        chk("R5 new", rgb_o, 24'hFF0000);

        // R6/R8/R7: held writes during active video
        active_i = 1; wr_en_i = 1; wr_addr_i = 20; wr_data_i = 16'h07E0; pix_idx_i = 20;
        step();
        chk("R6 busy", wr_busy_o, 1);
        wr_en_i = 0;
        step();
        chk("R6 untouched", rgb_o, 0);
        wr_en_i = 1; wr_data_i = 16'h001F;
        step();
        chk("R8 untouched", rgb_o, 0);
        wr_en_i = 0; active_i = 0;
        step();
        chk("R7 commit cycle old", rgb_o, 0);
        chk("R7 busy drop", wr_busy_o, 0);
        step();
        chk("R8 last wins", rgb_o, 24'h0000FF);

        // R9: blanking write while a write is held
        active_i = 1; wr_en_i = 1; wr_addr_i = 30; wr_data_i = 16'hFFFF;
        step();
        active_i = 0; wr_addr_i = 31; wr_data_i = 16'hF800; pix_idx_i = 30;
        step();
        chk("R9 busy stays", wr_busy_o, 1);
        chk("R9 commit cycle old", rgb_o, 0);
        wr_en_i = 0;
        step();
        chk("R7 visible", rgb_o, 24'hFFFFFF);
        chk("R9 busy drop", wr_busy_o, 0);
        pix_idx_i = 31;
        step();
        chk("R9 second stored", rgb_o, 24'hFF0000);

        // R10/R12/R11: override
        ovr_wr_i = 1; ovr_data_i = {1'b1, 24'h123456}; pix_idx_i = 30;
        step();
        chk("R10 same cycle palette", rgb_o, 24'hFFFFFF);
        ovr_wr_i = 0;
        step();
        chk("R10 forced", rgb_o, 24'h123456);
        wr_en_i = 1; wr_addr_i = 30; wr_data_i = 16'h0000;
        step();
        chk("R12 still forced", rgb_o, 24'h123456);
        wr_en_i = 0; ovr_wr_i = 1; ovr_data_i = {1'b0, 24'hABCDEF};
        step();
        chk("R11 same cycle forced", rgb_o, 24'h123456);
        ovr_wr_i = 0;
        step();
        chk("R12 stored under override", rgb_o, 0);
        pix_idx_i = 31;
        step();
        chk("R11 palette back", rgb_o, 24'hFF0000);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule